// File: doc/BRIEF.md
# Operand Address Resolver with Pointer Chasing

This block turns the addressing fields of a single-word memory-reference instruction into a final 15-bit operand address. The control logic gives it a 3-bit mode, an 11-bit address field, the program counter and two index registers (X and B), and pulses `start`. Direct, PC-relative and both indexed modes are pure arithmetic. They finish one clock after the start.

In the indirect modes the block fetches pointer words through a simple read port. It holds `rd_req` and `rd_addr` until the memory answers with `rd_valid` and `rd_data`. It keeps following pointer words until one has its continuation flag clear. Each pointer word costs exactly one read. A chain may have any length. The result is shown on `ea` with a one-clock `done` strobe. `reads` reports how many pointer words were fetched.

Top module: `ea_resolver`

## Requirements
- R1: Mode 000 (direct) yields `ea` equal to the 11-bit field zero-extended to 15 bits, with `done` high in the cycle after the accepted start and `reads` equal to 0.
- R2: Mode 001 (PC-relative) yields `ea` = (pc + field[8:0]) mod 2^15, where the offset is unsigned. Field bits 10:9 have no effect on the result.
- R3: Mode 010 (index X) yields `ea` = (idx_x + zero-extended field) mod 2^15, one cycle after start, with `reads` equal to 0.
- R4: Mode 011 (index B) yields `ea` = (idx_b + zero-extended field) mod 2^15, one cycle after start, with `reads` equal to 0.
- R5: Any mode with bit 2 set is indirect. The first read goes to the zero-extended field. In each returned word, bit 15 set means bits 14:0 point at another pointer word. Bit 15 clear means bits 14:0 are the final `ea`.
- R6: Every pointer word costs exactly one read, and chains of any depth are followed. At `done`, `reads` equals the number of words fetched for that resolution.
- R7: `done` is high for exactly one cycle per resolution. `ea` and `reads` hold their values until the next accepted start.
- R8: A start while a chain is being followed (`rd_req` high) is ignored. The running resolution completes with its own result and read count.
- R9: While `rd_req` is high and no `rd_valid` has arrived, `rd_addr` stays constant. When an indirect resolution begins, `rd_addr` equals the zero-extended field.
- R10: After reset, `done`, `rd_req`, `ea` and `reads` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a resolution (accepted only when idle) |
| mode | input | 3 | Addressing mode code |
| field | input | 11 | Instruction address field |
| pc | input | 15 | Program counter |
| idx_x | input | 15 | Index register X |
| idx_b | input | 15 | Index register B |
| rd_req | output | 1 | Pointer read request, held until answered |
| rd_addr | output | 15 | Pointer read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Pointer word: bit 15 continue flag, bits 14:0 address |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 15 | Resolved operand address |
| reads | output | 8 | Pointer words fetched by the last resolution |

## Verification
The assertions check the following on every cycle:
- `rd_addr` holds while a read is outstanding.
- The first pointer address is the field.
- `reads` advances by one per answered read.
- `ea` never moves without a `done`.
- Direct mode completes in one cycle with the field as its result.
- A done is never raised while a request is open.

Only the bench scenarios can show:
- The arithmetic of the relative and indexed modes, including their wraparound.
- That field bits above the relative offset have no effect.
- That chains of several lengths end at the right address with the right read count.
- That a start issued mid-chain leaves the result untouched.

// File: rtl/ea_resolver.sv
module ea_resolver #(
  parameter int AW = 15,
  parameter int FW = 11,
  parameter int RW = 9,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [FW-1:0] field,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_b,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [AW:0]   rd_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [CW-1:0] reads
);

  typedef enum logic {S_IDLE, S_WALK} st_t;
  st_t state;

  wire [AW-1:0] fld_ext = {{(AW-FW){1'b0}}, field};
  wire [AW-1:0] rel_off = {{(AW-RW){1'b0}}, field[RW-1:0]};

  logic [AW-1:0] calc;
  always_comb begin
    case (mode[1:0])
      2'b00:   calc = fld_ext;
      2'b01:   calc = pc + rel_off;
      2'b10:   calc = idx_x + fld_ext;
      default: calc = idx_b + fld_ext;
    endcase
  end

  assign rd_req = (state == S_WALK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rd_addr <= '0;
      ea      <= '0;
      reads   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          reads <= '0;
          if (mode[2]) begin
            state   <= S_WALK;
            rd_addr <= fld_ext;
          end else begin
            ea   <= calc;
            done <= 1'b1;
          end
        end
        S_WALK: if (rd_valid) begin
          reads <= reads + 1'b1;
          if (rd_data[AW]) begin
            rd_addr <= rd_data[AW-1:0];
          end else begin
            ea    <= rd_data[AW-1:0];
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module ea_resolver_chk #(
  parameter int AW = 15,
  parameter int FW = 11,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic [FW-1:0] field,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic [CW-1:0] reads
);

  assert_direct_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_req && mode == 3'b000) |=> (done && ea == {{(AW-FW){1'b0}}, $past(field)} && reads == '0));

  assert_first_ptr_is_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_req && mode[2]) |=> (rd_req && rd_addr == {{(AW-FW){1'b0}}, $past(field)}));

  assert_one_read_per_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (reads == CW'($past(reads) + 1'b1)));

  assert_ea_moves_only_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));

  assert_no_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rd_req));

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> $stable(rd_addr));

endmodule

bind ea_resolver ea_resolver_chk #(.AW(AW), .FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .done(done), .ea(ea), .reads(reads)
);

// File: tb/test_ea_resolver.sv
module test_ea_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [10:0] field = '0;
  logic [14:0] pc = '0, idx_x = '0, idx_b = '0;
  logic        rd_req;
  logic [14:0] rd_addr;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        done;
  logic [14:0] ea;
  logic [7:0]  reads;

  int checks = 0, errors = 0;
  logic [15:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_resolver i_ea_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .pc(pc), .idx_x(idx_x), .idx_b(idx_b), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .ea(ea), .reads(reads)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      rd_data  <= mem[rd_addr[7:0]];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(logic [2:0] m, logic [10:0] f);
    @(negedge clk);
    mode = m; field = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    check("R10 done", done, 0);
    check("R10 rd_req", rd_req, 0);
    check("R10 ea", ea, 0);
    check("R10 reads", reads, 0);
  endtask

  task automatic t_direct;
    pc = 15'h1234; idx_x = 15'h0111; idx_b = 15'h0222;
    launch(3'b000, 11'h5A5);
    check("R1 done next cycle", done, 1);
    check("R1 ea", ea, 15'h05A5);
    check("R1 reads", reads, 0);
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R7 ea held", ea, 15'h05A5);
  endtask

  task automatic t_relative;
    pc = 15'h7F00;
    launch(3'b001, 11'h7FF);
    check("R2 done", done, 1);
    check("R2 wrap and upper field bits ignored", ea, 15'h00FF);
    pc = 15'h0100;
    launch(3'b001, 11'h010);
    check("R2 plain", ea, 15'h0110);
  endtask

  task automatic t_index;
    idx_x = 15'h7FF0; idx_b = 15'h1000;
    launch(3'b010, 11'h020);
    check("R3 done", done, 1);
    check("R3 wrap", ea, 15'h0010);
    check("R3 reads", reads, 0);
    launch(3'b011, 11'h7FF);
    check("R4 done", done, 1);
    check("R4 ea", ea, 15'h17FF);
    check("R4 reads", reads, 0);
  endtask

  task automatic t_ind_single;
    int cyc;
    mem[40] = 16'h1234;
    launch(3'b100, 11'd40);
    check("R9 first address is field", rd_addr, 15'd40);
    check("R9 request open", rd_req, 1);
    wait_done(cyc);
    check("R5 single level ea", ea, 15'h1234);
    check("R6 single level reads", reads, 1);
    @(negedge clk);
    check("R7 done drops", done, 0);
    check("R7 reads held", reads, 1);
  endtask

  task automatic t_ind_chain;
    int cyc;
    for (int i = 0; i < 5; i++) mem[10 + 10*i] = 16'h8000 | 16'(20 + 10*i);
    mem[60] = 16'h7ABC;
    launch(3'b111, 11'd10);
    wait_done(cyc);
    check("R5 chain ea", ea, 15'h7ABC);
    check("R6 chain of six reads", reads, 6);
  endtask

  task automatic t_ignored_start;
    int cyc;
    mem[100] = 16'h8000 | 16'd110;
    mem[110] = 16'h8000 | 16'd120;
    mem[120] = 16'h0333;
    launch(3'b100, 11'd100);
    @(negedge clk);
    mode = 3'b000; field = 11'h055; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 no early done", done, 0);
    wait_done(cyc);
    check("R8 ea unaffected", ea, 15'h0333);
    check("R8 reads unaffected", reads, 3);
    @(negedge clk);
    check("R8 no extra done", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_direct();
    t_relative();
    t_index();
    t_ind_single();
    t_ind_chain();
    t_ignored_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule